// File: doc/BRIEF.md
# Protected Glitch-Free Clock Prescaler

This block divides a fast source clock by a power of two and presents the result as a one-cycle clock-enable pulse on the source clock. The CPU, the I/O logic, the converter logic and the flash interface all run from that one enable, so they all change speed together. The divider counter itself runs on the undivided source clock.

Software changes the division through an 8-bit control register. A change takes two writes. The first write must be exactly 0x80: the arm bit set and every other bit clear. The second write must come within four source cycles and must have the arm bit clear. Any other write pattern leaves the division unchanged. An accepted setting is held as pending. It takes effect only when the current divided period has run to its end. This means every gap between enable pulses equals either the old period or the new one, never a runt and never some intermediate value.

The write port is a plain strobe with no back-pressure. A write is taken on every cycle in which `wr_en` is high, and the read data is always valid.

Top module: `sysclk_prescaler`

## Requirements
- R1: While reset is asserted, `clk_en` is low. After reset, `rd_data` reads 0x00 and the division is 1, so `clk_en` is high on every cycle starting with the second cycle after reset is released.
- R2: While the block is not armed, a write of exactly 0x80 arms it, and `rd_data[7]` reads 1 on the next cycle.
- R3: While armed, a write with bit 7 = 0 and bits 3:0 = N, where N is at most 8, is accepted. The arm bit clears, and `rd_data[3:0]` reads N on the next cycle. The arm bit stays set for exactly four cycles after the arming write when no further write arrives, so a write on the fourth cycle after the arming write is still accepted. After that the arm bit clears by itself.
- R4: A write with bit 7 = 0 while the block is not armed is ignored. This includes a write that arrives after the window has expired.
- R5: A write with bit 7 = 1 and any other bit set, made while the block is not armed, does not arm it.
- R6: While armed, a write with bit 7 = 1 cancels the window. The arm bit clears and the field is unchanged.
- R7: While armed, a write with bit 7 = 0 and a reserved code from 9 to 15 in bits 3:0 closes the window and leaves the field unchanged.
- R8: With field N in effect, `clk_en` is a single-cycle pulse that repeats every 2^N source cycles.
- R9: A new setting takes effect only when the current period ends. Every interval between pulses equals 2^old or 2^new, and the first interval that starts after the accepting write's edge has already ended is 2^new.
- R10: `rd_data` holds the live arm bit in bit 7 and the last accepted field in bits 3:0. Bits 6:4 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Undivided source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one write per cycle it is high |
| wr_data | input | 8 | Register write data: bit 7 arm, bits 3:0 division exponent |
| rd_data | output | 8 | Register read data: live arm bit and last accepted exponent |
| clk_en | output | 1 | One-cycle enable marking each divided clock edge |

## Verification
The assertions assume that `wr_data` holds known values whenever `wr_en` is high. They also assume that reset is held for at least one clock edge, so the gap and window counters in the checker start from a defined state. The bench changes inputs only on the falling edge and samples `rd_data` and `clk_en` there as well. Its writes are one cycle long, and it places them on exact cycle offsets from the arming write so that the edges of the window are hit on purpose, as are mid-period switches in both directions.

// File: rtl/prescaler_pkg.sv
package prescaler_pkg;
  localparam int REG_W     = 8;
  localparam int ARM_BIT   = 7;
  localparam int SHIFT_W   = 4;
  localparam int MAX_SHIFT = 8;
  localparam int WIN_CYC   = 4;
  localparam logic [REG_W-1:0] ARM_KEY = 8'h80;

  typedef enum logic [1:0] {
    WR_NONE,
    WR_ARM,
    WR_APPLY,
    WR_DROP
  } wr_kind_e;
endpackage

// File: rtl/unlock_gate.sv
module unlock_gate
  import prescaler_pkg::*;
#(
  parameter int MAX_S = MAX_SHIFT,
  parameter int WIN   = WIN_CYC
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [REG_W-1:0]   wr_data,
  output logic               armed,
  output logic [SHIFT_W-1:0] field,
  output logic               chg_vld,
  output logic [SHIFT_W-1:0] chg_shift
);
  localparam int WIN_W = $clog2(WIN + 1);
  localparam logic [SHIFT_W-1:0] MAX_CODE = SHIFT_W'(MAX_S);
  localparam logic [WIN_W-1:0]   WIN_LD   = WIN_W'(WIN);

  logic [WIN_W-1:0]   win_q;
  logic [SHIFT_W-1:0] field_q;
  logic [SHIFT_W-1:0] code;
  wr_kind_e           kind;

  assign armed = (win_q != '0);
  assign code  = wr_data[SHIFT_W-1:0];

  // classify the write against the current window state
  always_comb begin
    kind = WR_NONE;
    if (wr_en) begin
      if (armed) begin
        if (!wr_data[ARM_BIT] && (code <= MAX_CODE)) kind = WR_APPLY;
        else                                         kind = WR_DROP;
      end else if (wr_data == ARM_KEY) begin
        kind = WR_ARM;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q   <= '0;
      field_q <= '0;
    end else begin
      unique case (kind)
        WR_ARM:   win_q <= WIN_LD;
        WR_APPLY: begin
          win_q   <= '0;
          field_q <= code;
        end
        WR_DROP:  win_q <= '0;
        default:  if (armed) win_q <= win_q - 1'b1;
      endcase
    end
  end

  assign field     = field_q;
  assign chg_vld   = (kind == WR_APPLY);
  assign chg_shift = code;
endmodule

// File: rtl/tick_divider.sv
module tick_divider
  import prescaler_pkg::*;
#(
  parameter int MAX_S = MAX_SHIFT
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               chg_vld,
  input  logic [SHIFT_W-1:0] chg_shift,
  output logic               tick
);
  localparam int CNT_W = (MAX_S > 0) ? MAX_S : 1;

  logic               live_q;
  logic               pend_q;
  logic [SHIFT_W-1:0] pend_shift_q;
  logic [SHIFT_W-1:0] act_shift_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [CNT_W-1:0]   mask;

  // terminal count for the active exponent: low act_shift bits set
  always_comb begin
    for (int i = 0; i < CNT_W; i++) begin
      mask[i] = (i < int'(act_shift_q));
    end
  end

  assign tick = live_q && (cnt_q == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q      <= 1'b0;
      cnt_q       <= '0;
      act_shift_q <= '0;
    end else begin
      live_q <= 1'b1;
      if (tick) begin
        cnt_q <= '0;
        if (pend_q) act_shift_q <= pend_shift_q;
      end else if (live_q) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // a setting accepted on a boundary edge waits for the following one
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q       <= 1'b0;
      pend_shift_q <= '0;
    end else if (chg_vld) begin
      pend_q       <= 1'b1;
      pend_shift_q <= chg_shift;
    end else if (tick) begin
      pend_q <= 1'b0;
    end
  end
endmodule

// File: rtl/sysclk_prescaler.sv
module sysclk_prescaler
  import prescaler_pkg::*;
#(
  parameter int MAX_S = MAX_SHIFT,
  parameter int WIN   = WIN_CYC
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  output logic             clk_en
);
  logic               armed;
  logic [SHIFT_W-1:0] field;
  logic               chg_vld;
  logic [SHIFT_W-1:0] chg_shift;

  unlock_gate #(.MAX_S(MAX_S), .WIN(WIN)) u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .armed     (armed),
    .field     (field),
    .chg_vld   (chg_vld),
    .chg_shift (chg_shift)
  );

  tick_divider #(.MAX_S(MAX_S)) u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .chg_vld   (chg_vld),
    .chg_shift (chg_shift),
    .tick      (clk_en)
  );

  always_comb begin
    rd_data                = '0;
    rd_data[ARM_BIT]       = armed;
    rd_data[SHIFT_W-1:0]   = field;
  end
endmodule

// File: rtl/prescaler_chk.sv
module prescaler_chk
  import prescaler_pkg::*;
#(
  parameter int MAX_S = MAX_SHIFT,
  parameter int WIN   = WIN_CYC
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [REG_W-1:0] wr_data,
  input logic [REG_W-1:0] rd_data,
  input logic             clk_en
);
  localparam int GAP_W = MAX_S + 2;
  localparam int WC_W  = $clog2(WIN + 2);

  logic [GAP_W-1:0] gap_q;
  logic             seen_q;
  logic [WC_W-1:0]  idle_arm_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q      <= GAP_W'(1);
      seen_q     <= 1'b0;
      idle_arm_q <= '0;
    end else begin
      if (clk_en) begin
        gap_q  <= GAP_W'(1);
        seen_q <= 1'b1;
      end else if (gap_q != '1) begin
        gap_q <= gap_q + 1'b1;
      end
      if (rd_data[ARM_BIT] && !wr_en) idle_arm_q <= idle_arm_q + 1'b1;
      else                            idle_arm_q <= '0;
    end
  end

  AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |-> !clk_en); // R1

  AST_ARM_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_data[ARM_BIT] && wr_en && wr_data == ARM_KEY) |=> rd_data[ARM_BIT]); // R2

  AST_WINDOW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[ARM_BIT] && !wr_en) |-> (int'(idle_arm_q) < WIN)); // R3

  AST_LOCKED_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_data[ARM_BIT] && wr_en && !wr_data[ARM_BIT]) |=> ($stable(rd_data[3:0]) && !rd_data[ARM_BIT])); // R4

  AST_CANCEL: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[ARM_BIT] && wr_en && wr_data[ARM_BIT]) |=> ($stable(rd_data[3:0]) && !rd_data[ARM_BIT])); // R6

  AST_RESERVED_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[ARM_BIT] && wr_en && !wr_data[ARM_BIT] && wr_data[3:0] > 4'd8) |=> ($stable(rd_data[3:0]) && !rd_data[ARM_BIT])); // R7

  AST_PERIOD_POW2: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && seen_q) |-> ($countones(gap_q) == 1 && int'(gap_q) <= (1 << MAX_S))); // R9

  AST_READ_ZEROS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[6:4] == 3'b000); // R10
endmodule

bind sysclk_prescaler prescaler_chk #(.MAX_S(MAX_S), .WIN(WIN)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_en   (wr_en),
  .wr_data (wr_data),
  .rd_data (rd_data),
  .clk_en  (clk_en)
);

// File: tb/sysclk_prescaler_test.sv
module sysclk_prescaler_test;
  localparam int CLK_PER = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       clk_en;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  string cur_tag = "R1";

  // behavioural reference state
  bit m_live = 0;
  int m_left = 1;
  int m_act = 0;
  bit m_pend = 0;
  int m_pshift = 0;
  int m_win = 0;
  int m_field = 0;

  sysclk_prescaler uut (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_data (rd_data),
    .clk_en  (clk_en)
  );

  always #(CLK_PER/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // reference model advances on each rising edge
  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_live = 0; m_left = 1; m_act = 0; m_pend = 0;
      m_win = 0; m_field = 0;
    end else begin
      if (!m_live) begin
        m_live = 1;
        m_left = 1 << m_act;
      end else if (m_left == 1) begin
        if (m_pend) begin
          m_act = m_pshift;
          m_pend = 0;
        end
        m_left = 1 << m_act;
      end else begin
        m_left--;
      end
      if (wr_en) begin
        if (m_win > 0) begin
          m_win = 0;
          if (!wr_data[7] && int'(wr_data[3:0]) <= 8) begin
            m_field = int'(wr_data[3:0]);
            m_pend = 1;
            m_pshift = m_field;
          end
        end else if (wr_data == 8'h80) begin
          m_win = 4;
        end
      end else if (m_win > 0) begin
        m_win--;
      end
    end
    if (cyc > 100000) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      int exp_rd;
      int exp_en;
      exp_rd = ((m_win > 0) ? 128 : 0) + m_field;
      exp_en = (m_live && m_left == 1) ? 1 : 0;
      check(rd_data == 8'(exp_rd), {cur_tag, " rd_data"}, rd_data, exp_rd);
      check(clk_en == exp_en[0], {cur_tag, " clk_en"}, clk_en, exp_en);
    end
  end

  task automatic wr(input logic [7:0] d);
    wr_en = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    wr_data = 8'h00;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (4) begin
      @(negedge clk);
      check(clk_en == 1'b0, "R1 enable low in reset", clk_en, 0);
    end
    rst_n = 1'b1;
    check(rd_data == 8'h00, "R1 reset read", rd_data, 0);
    idle(2);
    check(clk_en == 1'b1, "R1 divide by one", clk_en, 1);
    cur_tag = "R8";
    idle(6);

    cur_tag = "R4";
    wr(8'h03);
    check(rd_data == 8'h00, "R4 locked write ignored", rd_data, 8'h00);

    cur_tag = "R5";
    wr(8'h81);
    check(rd_data[7] == 1'b0, "R5 impure key no arm", rd_data[7], 0);

    cur_tag = "R2";
    wr(8'h80);
    check(rd_data == 8'h80, "R2 armed", rd_data, 8'h80);
    idle(2);
    cur_tag = "R3";
    wr(8'h02);
    check(rd_data == 8'h02, "R3 accept in window", rd_data, 8'h02);
    cur_tag = "R8";
    idle(24);

    cur_tag = "R3";
    wr(8'h80);
    idle(3);
    check(rd_data[7] == 1'b1, "R3 still armed at slot 4", rd_data[7], 1);
    idle(1);
    check(rd_data[7] == 1'b0, "R3 window expired", rd_data[7], 0);
    cur_tag = "R4";
    wr(8'h05);
    check(rd_data == 8'h02, "R4 late write ignored", rd_data, 8'h02);

    cur_tag = "R3";
    wr(8'h80);
    idle(3);
    wr(8'h04);
    check(rd_data == 8'h04, "R3 accept at last slot", rd_data, 8'h04);
    cur_tag = "R9";
    idle(45);

    cur_tag = "R6";
    wr(8'h80);
    wr(8'h80);
    check(rd_data == 8'h04, "R6 cancel keeps field", rd_data, 8'h04);
    wr(8'h01);
    check(rd_data == 8'h04, "R6 write after cancel ignored", rd_data, 8'h04);

    cur_tag = "R7";
    wr(8'h80);
    wr(8'h0C);
    check(rd_data == 8'h04, "R7 reserved code", rd_data, 8'h04);
    idle(3);

    cur_tag = "R9";
    wr(8'h80);
    wr(8'h00);
    idle(40);
    wr(8'h80);
    idle(1);
    wr(8'h08);
    idle(600);
    wr(8'h80);
    wr(8'h01);
    check(rd_data == 8'h01, "R10 field readback", rd_data, 8'h01);
    idle(300);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule